// File: doc/BRIEF.md
# Registered Two-Port Bus Transceiver

This block moves an 18-bit word between two ports, A and B, in both directions at once. Each direction has its own bank of storage cells. A level-sensitive enable makes a bank transparent. With that enable low, the bank holds its word, and a rising edge on that direction's control clock loads a new word. The control clocks are ordinary inputs. They are sampled in the system clock domain, and a rising edge is found by comparing each sample with the one before it.

Each port has a data-in bus, a data-out bus and a drive-enable output, so a wrapper at the chip edge can build the real tri-state pads. Each port also has an input-valid qualifier. While the qualifier is low, the block uses the last word it saw while the qualifier was high, as a bus keeper would on an undriven line. If both ports are asked to drive at the same time, the block raises a contention flag. Both directions keep working in that case.

Top module: `regbus_xcvr`

## Requirements
- R1: Every bit of the WIDTH-bit word (default 18) is carried independently in both directions. An all-ones or alternating word arrives unchanged.
- R2: While `ab_le` is 1, `b_dout` equals the effective A input in the same cycle. The bank also tracks that value, so after `ab_le` falls it keeps the word present at the last system clock edge with `ab_le` high. The same holds for `ba_le` and `a_dout`.
- R3: While the latch enable is 0 and no control-clock rise is seen, the stored word and the data output do not change, whatever the data inputs do.
- R4: While the latch enable is 0, a control-clock rise loads the effective input at that system clock edge. A rise is a control clock sampled 1 at this edge and 0 at the previous edge. The new word appears on the data output from the next cycle.
- R5: A control-clock rise while the latch enable is 1 changes nothing beyond the transparent pass-through.
- R6: `b_oe` equals `ab_oe` (active-high), and `a_oe` equals the inverse of `ba_oe_n` (active-low). Both are 0 whenever `rst_n` is 0.
- R7: When a port's valid qualifier is 0, its effective input is the last word sampled while the qualifier was 1. Otherwise the effective input is the data-in bus.
- R8: A system clock edge with `rst_n` at 0 clears both storage banks and both held input words to zero. The first edge after reset never counts as a control-clock rise.
- R9: `contention` is 1 exactly when `b_oe` and `a_oe` are both 1.
- R10: A control clock that stays high gives one load only. Later edges with it still high hold the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_din | input | WIDTH | Word arriving at port A |
| a_din_vld | input | 1 | Port A is being driven |
| b_din | input | WIDTH | Word arriving at port B |
| b_din_vld | input | 1 | Port B is being driven |
| ab_le | input | 1 | A-to-B transparent enable |
| ab_clk | input | 1 | A-to-B load clock (sampled) |
| ab_oe | input | 1 | Port B drive request, active-high |
| ba_le | input | 1 | B-to-A transparent enable |
| ba_clk | input | 1 | B-to-A load clock (sampled) |
| ba_oe_n | input | 1 | Port A drive request, active-low |
| b_dout | output | WIDTH | Word to drive onto port B |
| b_oe | output | 1 | Port B drive enable |
| a_dout | output | WIDTH | Word to drive onto port A |
| a_oe | output | 1 | Port A drive enable |
| contention | output | 1 | Both ports drive at once |

## Verification
Two cases are forced to coincide. In the first, a control-clock rise arrives while the latch enable is high. In the second, a load falls in a cycle where the valid qualifier is low, so the held word, not the live bus, must be captured. A long pseudo-random sweep lets enable, clock, qualifier and data change every cycle, and directed steps set up each case on purpose. Every cycle, the bench compares both data outputs, both enables and the contention flag against a model built from the requirements.

// File: rtl/xcvr_pkg.sv
// Shared types for the registered transceiver.
// Assumes: one mode value per direction per system clock cycle.
package xcvr_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD    = 2'd0,
        MODE_PASS    = 2'd1,
        MODE_CAPTURE = 2'd2
    } cell_mode_e;

    // Pick a bank's mode from the level enable and a detected clock rise.
    function automatic cell_mode_e pick_mode(input logic le, input logic rise);
        if (le)        return MODE_PASS;
        else if (rise) return MODE_CAPTURE;
        else           return MODE_HOLD;
    endfunction
endpackage

// File: rtl/xcvr_bus_hold.sv
// Keeper for one input port. It forwards the live word while the valid
// qualifier is high and otherwise the last word seen while it was high.
// Assumes: synchronous active-low reset clears the held word to zero.
module xcvr_bus_hold #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic             vld,
    output logic [WIDTH-1:0] eff
);
    logic [WIDTH-1:0] held_q;

    // Record the live word whenever the port is driven.
    always_ff @(posedge clk) begin
        if (!rst_n)   held_q <= '0;
        else if (vld) held_q <= din;
    end

    // Choose the live or the kept word.
    always_comb eff = vld ? din : held_q;

    p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |=> $stable(held_q));
    p_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> (held_q == $past(din)));
endmodule

// File: rtl/xcvr_rise_det.sv
// Finds rising edges of a slow control clock by sampling it with the
// system clock. Assumes: the control clock is already synchronous. The
// sampled state resets high, so no rise is seen right after reset.
module xcvr_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_clk,
    output logic rise
);
    logic prev_q;

    // Remember the previous sample of the control clock.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= ctl_clk;
    end

    // A rise is high now and low at the previous sample.
    always_comb rise = ctl_clk & ~prev_q;

    p_single_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/xcvr_bit_cell.sv
// One bit of a direction's storage. It merges a transparent latch with an
// edge-loaded register. Assumes: the mode comes from the owning path and
// is valid every cycle.
module xcvr_bit_cell
    import xcvr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cell_mode_e mode,
    input  logic       d,
    output logic       q
);
    logic store_q;

    // Load in pass or capture mode, keep in hold mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                 store_q <= 1'b0;
        else if (mode != MODE_HOLD) store_q <= d;
    end

    // Transparent output in pass mode, stored bit otherwise.
    always_comb q = (mode == MODE_PASS) ? d : store_q;

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD) |=> $stable(store_q));
    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CAPTURE) |=> (store_q == $past(d)));
    p_clear_r8: assert property (@(posedge clk)
        !rst_n |=> (store_q == 1'b0));
endmodule

// File: rtl/xcvr_path.sv
// One direction of the transceiver: an edge detector for its control clock
// and one storage cell per bit. Assumes: d_in is the effective word after
// the keeper.
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             le,
    input  logic             ctl_clk,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic       rise;
    cell_mode_e mode;

    xcvr_rise_det u_rise (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_clk (ctl_clk),
        .rise    (rise)
    );

    // Work out this direction's mode for the cycle.
    always_comb mode = pick_mode(le, rise);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        xcvr_bit_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (mode),
            .d     (d_in[i]),
            .q     (q_out[i])
        );
    end

    p_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        le |=> (!le |-> (q_out == $past(d_in))));
    p_rise_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (le && rise) |-> (q_out == d_in));
endmodule

// File: rtl/regbus_xcvr.sv
// Top of the two-port registered bus transceiver. It chains a keeper per
// port, a storage path per direction and the drive-enable logic.
// Assumes: pads are built outside, and reset is synchronous active-low.
module regbus_xcvr #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_din,
    input  logic             a_din_vld,
    input  logic [WIDTH-1:0] b_din,
    input  logic             b_din_vld,
    input  logic             ab_le,
    input  logic             ab_clk,
    input  logic             ab_oe,
    input  logic             ba_le,
    input  logic             ba_clk,
    input  logic             ba_oe_n,
    output logic [WIDTH-1:0] b_dout,
    output logic             b_oe,
    output logic [WIDTH-1:0] a_dout,
    output logic             a_oe,
    output logic             contention
);
    logic [WIDTH-1:0] a_eff;
    logic [WIDTH-1:0] b_eff;

    xcvr_bus_hold #(.WIDTH(WIDTH)) u_hold_a (
        .clk (clk), .rst_n (rst_n), .din (a_din), .vld (a_din_vld), .eff (a_eff)
    );
    xcvr_bus_hold #(.WIDTH(WIDTH)) u_hold_b (
        .clk (clk), .rst_n (rst_n), .din (b_din), .vld (b_din_vld), .eff (b_eff)
    );

    xcvr_path #(.WIDTH(WIDTH)) u_ab (
        .clk (clk), .rst_n (rst_n), .le (ab_le), .ctl_clk (ab_clk),
        .d_in (a_eff), .q_out (b_dout)
    );
    xcvr_path #(.WIDTH(WIDTH)) u_ba (
        .clk (clk), .rst_n (rst_n), .le (ba_le), .ctl_clk (ba_clk),
        .d_in (b_eff), .q_out (a_dout)
    );

    // Drive enables, both forced off while reset is held.
    always_comb begin
        b_oe       = rst_n & ab_oe;
        a_oe       = rst_n & ~ba_oe_n;
        contention = b_oe & a_oe;
    end

    p_oe_reset_r6: assert property (@(posedge clk)
        !rst_n |-> (!b_oe && !a_oe));
    p_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_oe || ba_oe_n) |-> !contention);
endmodule

// File: tb/sim_regbus_xcvr.sv
`timescale 1ns/1ps
module sim_regbus_xcvr;
    localparam int W = 18;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst_n = 1'b0;
    logic [W-1:0] a_din = '0, b_din = '0;
    logic         a_vld = 1'b0, b_vld = 1'b0;
    logic         ab_le = 1'b0, ab_clk = 1'b0, ab_oe = 1'b0;
    logic         ba_le = 1'b0, ba_clk = 1'b0, ba_oe_n = 1'b1;
    logic [W-1:0] b_dout, a_dout;
    logic         b_oe, a_oe, contention;

    regbus_xcvr #(.WIDTH(W)) u0 (
        .clk (clk), .rst_n (rst_n),
        .a_din (a_din), .a_din_vld (a_vld), .b_din (b_din), .b_din_vld (b_vld),
        .ab_le (ab_le), .ab_clk (ab_clk), .ab_oe (ab_oe),
        .ba_le (ba_le), .ba_clk (ba_clk), .ba_oe_n (ba_oe_n),
        .b_dout (b_dout), .b_oe (b_oe), .a_dout (a_dout), .a_oe (a_oe),
        .contention (contention)
    );

    int checks = 0;
    int fails  = 0;

    // Model state, built from the requirements.
    logic [W-1:0] m_hold_a = '0, m_hold_b = '0, m_st_ab = '0, m_st_ba = '0;
    logic         m_prev_ab = 1'b1, m_prev_ba = 1'b1;
    string        tag_ab = "R8", tag_ba = "R8";
    logic [31:0]  lfsr = 32'h1234_5678;

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    // Compare all outputs against the model, mid-cycle.
    task automatic check_outputs();
        logic [W-1:0] ea = a_vld ? a_din : m_hold_a;
        logic [W-1:0] eb = b_vld ? b_din : m_hold_b;
        string t;
        logic exp_boe = rst_n & ab_oe;
        logic exp_aoe = rst_n & ~ba_oe_n;
        t = ab_le ? (!a_vld ? "R7" : ((ab_clk && !m_prev_ab) ? "R5" : "R2")) : tag_ab;
        chk(t, b_dout, ab_le ? ea : m_st_ab);
        t = ba_le ? (!b_vld ? "R7" : ((ba_clk && !m_prev_ba) ? "R5" : "R2")) : tag_ba;
        chk(t, a_dout, ba_le ? eb : m_st_ba);
        chk("R6", {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, exp_boe});
        chk("R6", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, exp_aoe});
        chk("R9", {{(W-1){1'b0}}, contention}, {{(W-1){1'b0}}, exp_boe & exp_aoe});
    endtask

    // Advance the model by one system clock edge with the present inputs.
    task automatic model_edge();
        logic [W-1:0] ea = a_vld ? a_din : m_hold_a;
        logic [W-1:0] eb = b_vld ? b_din : m_hold_b;
        if (!rst_n) begin
            m_hold_a = '0; m_hold_b = '0; m_st_ab = '0; m_st_ba = '0;
            m_prev_ab = 1'b1; m_prev_ba = 1'b1; tag_ab = "R8"; tag_ba = "R8";
        end else begin
            if (ab_le) begin m_st_ab = ea; tag_ab = "R2"; end
            else if (ab_clk && !m_prev_ab) begin
                m_st_ab = ea; tag_ab = a_vld ? "R4" : "R7";
            end else tag_ab = ab_clk ? "R10" : "R3";
            if (ba_le) begin m_st_ba = eb; tag_ba = "R2"; end
            else if (ba_clk && !m_prev_ba) begin
                m_st_ba = eb; tag_ba = b_vld ? "R4" : "R7";
            end else tag_ba = ba_clk ? "R10" : "R3";
            m_prev_ab = ab_clk; m_prev_ba = ba_clk;
            m_hold_a = ea; m_hold_b = eb;
        end
    endtask

    task automatic cycle();
        #3;
        check_outputs();
        model_edge();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog act=running exp=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(posedge clk); #1;
        repeat (3) cycle();
        rst_n = 1'b1;
        // R8: cleared banks after reset, enables off.
        cycle();
        chk("R8", b_dout, '0);
        chk("R8", a_dout, '0);
        // R1/R4: all-ones load into A-to-B, alternating into B-to-A.
        a_din = '1; b_din = 18'h2AAAA; a_vld = 1; b_vld = 1;
        cycle();
        ab_clk = 1; ba_clk = 1;
        cycle();
        chk("R1", b_dout, 18'h3FFFF);
        chk("R1", a_dout, 18'h2AAAA);
        // R10: clock held high, data changes, no reload.
        a_din = 18'h15555; b_din = 18'h00001;
        cycle(); cycle();
        chk("R10", b_dout, 18'h3FFFF);
        // R7: undriven port, then a load captures the kept word.
        a_vld = 0; a_din = 18'h00F0F; ab_clk = 0;
        cycle();
        ab_clk = 1;
        cycle();
        chk("R7", b_dout, 18'h15555);
        // R5: rise during transparency, then close the latch.
        a_vld = 1; a_din = 18'h0C0C0; ab_le = 1; ab_clk = 0;
        cycle();
        ab_clk = 1;
        cycle();
        ab_le = 0;
        cycle();
        chk("R5", b_dout, 18'h0C0C0);
        // R9: both sides drive.
        ab_oe = 1; ba_oe_n = 0;
        cycle();
        chk("R9", {17'b0, contention}, 18'h1);
        // Sweep: all controls and data change pseudo-randomly.
        for (int n = 0; n < 4000; n++) begin
            lfsr = nxt(lfsr);
            ab_le   = (lfsr[1:0] == 2'b00);
            ba_le   = (lfsr[3:2] == 2'b00);
            ab_clk  = lfsr[4];
            ba_clk  = lfsr[5];
            a_vld   = (lfsr[7:6] != 2'b00);
            b_vld   = (lfsr[9:8] != 2'b00);
            ab_oe   = lfsr[10];
            ba_oe_n = lfsr[11];
            rst_n   = !(n >= 2000 && n < 2003);
            lfsr = nxt(lfsr);
            a_din = lfsr[W-1:0];
            b_din = lfsr[31:32-W];
            cycle();
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule